// File: doc/BRIEF.md
# Static Word Memory with Dual-Polarity Select

This block is a synthesizable model of an asynchronous-style static memory, 8192 words of 8 bits by default. Two select pins of opposite polarity must both be active before the device does anything. A separate active-low output-enable pin and an active-low write-enable pin then choose between storing a word and presenting one. The bidirectional data bus of a real part is split into a data input, a data output and an output-drive flag. The drive flag is high exactly when the bus would be driven. When the flag is low, a board-level wrapper would leave the pins floating.

Writes are captured on the rising clock edge whenever the write condition holds. Read data comes either straight from the addressed cell in the same cycle or, when the `READ_REG` parameter is set, from a register loaded at the last clock edge. Both the write enable and the output enable are active low. The write enable wins over the output enable, so the device never drives the bus while it is storing. A standby flag follows the active-low select and stands in for the low-power state of the device when it is deselected.

Top module: `sram_dual_sel`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (8192 by 8 by default). Every address, including the first (0) and the last (8191), stores a word independently of the others.
- R2: When sel_n_i is 0, sel_i is 1 and we_n_i is 0 at a rising clk_i edge, din_i is stored at addr_i.
- R3: dout_oe_o is 1 exactly when sel_n_i is 0, sel_i is 1, oe_n_i is 0 and we_n_i is 1. This covers all 16 combinations of the four control pins.
- R4: While we_n_i is 0, dout_oe_o is 0 whatever the level of oe_n_i.
- R5: While the device is deselected (sel_n_i is 1 or sel_i is 0), dout_oe_o is 0.
- R6: standby_o equals sel_n_i.
- R7: At a clock edge with the device deselected or with we_n_i at 1, no word of the array changes, whatever addr_i and din_i carry.
- R8: With READ_REG at 0, dout_o shows the word at the current addr_i in the same cycle.
- R9: With READ_REG at 1, dout_o shows the word that was at addr_i at the previous rising edge, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock that samples writes and the registered read |
| rst_ni | input | 1 | Active-low reset of the read register |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Data to be stored |
| sel_n_i | input | 1 | Active-low device select |
| sel_i | input | 1 | Active-high device select |
| oe_n_i | input | 1 | Active-low output enable |
| we_n_i | input | 1 | Active-low write enable |
| dout_o | output | DATA_W | Read data |
| dout_oe_o | output | 1 | High when the data bus is driven |
| standby_o | output | 1 | Deselected low-power indication |

## Verification
The assertions assume that addr_i, din_i and the four control pins are stable around each rising clock edge. The array checks only say something when addr_i holds the same value across two edges. The stimulus therefore changes every input on the falling edge only, and it holds each address for a full cycle before and after a write. The array is never initialised, so every read in the stimulus targets an address that was written first.

// File: rtl/sram_dual_sel_pkg.sv
package sram_dual_sel_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } mem_op_e;
endpackage

// File: rtl/sram_ds_decode.sv
module sram_ds_decode
   import sram_dual_sel_pkg::*;
(
   input  logic    sel_n,
   input  logic    sel,
   input  logic    oe_n,
   input  logic    we_n,
   output mem_op_e op,
   output logic    standby
);
   logic chip_on;

   always_comb begin
      chip_on = !sel_n && sel;
      if (chip_on && !we_n)
         op = OP_WRITE;
      else if (chip_on && !oe_n)
         op = OP_READ;
      else
         op = OP_IDLE;
      standby = sel_n;
   end
endmodule

// File: rtl/sram_ds_store.sv
module sram_ds_store #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rword
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         cells[addr] <= wdata;
   end

   assign rword = cells[addr];

   // R2
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ($stable(addr) ? (rword == $past(wdata)) : 1'b1));

   // R7
   no_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(addr) ? $stable(rword) : 1'b1));
endmodule

// File: rtl/sram_ds_drive.sv
module sram_ds_drive #(
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] rword,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);
   assign dout_oe = rd_en;

   generate
      if (READ_REG) begin : g_reg
         logic [DATA_W-1:0] dout_q;
         logic              primed_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dout_q   <= '0;
               primed_q <= 1'b0;
            end else begin
               dout_q   <= rword;
               primed_q <= 1'b1;
            end
         end
         assign dout = dout_q;

         // R9
         reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed_q |-> (dout == $past(rword)));
      end else begin : g_comb
         assign dout = rword;

         // R8
         comb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(rword) |-> $stable(dout));
      end
   endgenerate
endmodule

// File: rtl/sram_dual_sel.sv
module sram_dual_sel
   import sram_dual_sel_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int DATA_W   = 8,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] din_i,
   input  logic              sel_n_i,
   input  logic              sel_i,
   input  logic              oe_n_i,
   input  logic              we_n_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              dout_oe_o,
   output logic              standby_o
);
   mem_op_e          op;
   logic [DATA_W-1:0] rword;

   initial begin
      addr_range_chk: assert (ADDR_W >= 1 && ADDR_W <= 20)
         else $error("ADDR_W out of range");
      data_range_chk: assert (DATA_W >= 1 && DATA_W <= 64)
         else $error("DATA_W out of range");
   end

   sram_ds_decode u_decode (
      .sel_n   (sel_n_i),
      .sel     (sel_i),
      .oe_n    (oe_n_i),
      .we_n    (we_n_i),
      .op      (op),
      .standby (standby_o)
   );

   sram_ds_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk_i),
      .rst_n (rst_ni),
      .wr_en (op == OP_WRITE),
      .addr  (addr_i),
      .wdata (din_i),
      .rword (rword)
   );

   sram_ds_drive #(.DATA_W(DATA_W), .READ_REG(READ_REG)) u_drive (
      .clk     (clk_i),
      .rst_n   (rst_ni),
      .rd_en   (op == OP_READ),
      .rword   (rword),
      .dout    (dout_o),
      .dout_oe (dout_oe_o)
   );

   // R4
   write_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_n_i |-> !dout_oe_o);

   // R5
   desel_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_n_i || !sel_i) |-> !dout_oe_o);

   // R3
   drive_needs_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dout_oe_o |-> (!oe_n_i && we_n_i));

   // R6
   standby_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      standby_o |-> !dout_oe_o);
endmodule

// File: tb/tb_sram_dual_sel.sv
module tb_sram_dual_sel;
   localparam int AW = 13;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic          sel_n = 1'b1, sel = 1'b0, oe_n = 1'b1, we_n = 1'b1;
   logic [DW-1:0] dout_c, dout_r;
   logic          oe_c, oe_r, sb_c, sb_r;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sram_dual_sel #(.ADDR_W(AW), .DATA_W(DW), .READ_REG(1'b0)) dut (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .din_i(din),
      .sel_n_i(sel_n), .sel_i(sel), .oe_n_i(oe_n), .we_n_i(we_n),
      .dout_o(dout_c), .dout_oe_o(oe_c), .standby_o(sb_c));

   sram_dual_sel #(.ADDR_W(AW), .DATA_W(DW), .READ_REG(1'b1)) dut_q (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .din_i(din),
      .sel_n_i(sel_n), .sel_i(sel), .oe_n_i(oe_n), .we_n_i(we_n),
      .dout_o(dout_r), .dout_oe_o(oe_r), .standby_o(sb_r));

   // {sel_n, sel, oe_n, we_n, expected drive}
   localparam logic [4:0] CTRL_TBL [16] = '{
      5'b0000_0, 5'b0001_0, 5'b0010_0, 5'b0011_0,
      5'b0100_0, 5'b0101_1, 5'b0110_0, 5'b0111_0,
      5'b1000_0, 5'b1001_0, 5'b1010_0, 5'b1011_0,
      5'b1100_0, 5'b1101_0, 5'b1110_0, 5'b1111_0
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      sel_n = 1'b1; sel = 1'b0; oe_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; din = d; sel_n = 1'b0; sel = 1'b1; oe_n = 1'b0; we_n = 1'b0;
      #1;
      chk("R4 no drive during write", {31'd0, oe_c}, 32'd0);
      go_idle();
   endtask

   task automatic read_word(input logic [AW-1:0] a, input logic [DW-1:0] exp);
      @(negedge clk);
      addr = a; sel_n = 1'b0; sel = 1'b1; oe_n = 1'b0; we_n = 1'b1;
      #1;
      chk("R3 read drives", {31'd0, oe_c}, 32'd1);
      chk("R8 same-cycle read", {24'd0, dout_c}, {24'd0, exp});
      @(posedge clk);
      #1;
      chk("R9 registered read", {24'd0, dout_r}, {24'd0, exp});
      go_idle();
   endtask

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      chk("R5 reset no drive", {31'd0, oe_c}, 32'd0);
      chk("R6 reset standby", {31'd0, sb_c}, 32'd1);
      chk("R9 reset value", {24'd0, dout_r}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk over all control combinations at address 100
      write_word(13'd100, 8'h77);
      din = 8'h77;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         addr = 13'd100; din = 8'h77;
         {sel_n, sel, oe_n, we_n} = CTRL_TBL[i][4:1];
         #1;
         chk("R3 R5 control table drive", {31'd0, oe_c}, {31'd0, CTRL_TBL[i][0]});
         chk("R6 standby follows select", {31'd0, sb_c}, {31'd0, CTRL_TBL[i][4]});
         if (CTRL_TBL[i][0])
            chk("R8 table read", {24'd0, dout_c}, 32'h77);
      end
      go_idle();

      // R1 corner addresses
      write_word(13'd0, 8'hA5);
      write_word(13'd8191, 8'h5A);
      write_word(13'd1234, 8'h3C);
      read_word(13'd0, 8'hA5);
      read_word(13'd8191, 8'h5A);
      read_word(13'd1234, 8'h3C);

      // R7 deselected or write-disabled edges leave contents alone
      @(negedge clk);
      addr = 13'd0; din = 8'hFF; sel_n = 1'b1; sel = 1'b1; oe_n = 1'b1; we_n = 1'b0;
      #1;
      chk("R6 standby when deselected", {31'd0, sb_c}, 32'd1);
      @(negedge clk);
      addr = 13'd8191; din = 8'h00; sel_n = 1'b0; sel = 1'b0; we_n = 1'b0;
      #1;
      chk("R5 low-side select off", {31'd0, oe_c}, 32'd0);
      @(negedge clk);
      addr = 13'd1234; din = 8'h00; sel_n = 1'b0; sel = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      go_idle();
      read_word(13'd0, 8'hA5);
      read_word(13'd8191, 8'h5A);
      read_word(13'd1234, 8'h3C);

      // R2 overwrite and R4 with output enable low
      write_word(13'd8191, 8'hC3);
      read_word(13'd8191, 8'hC3);
      read_word(13'd0, 8'hA5);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule